// File: doc/BRIEF.md
# Programmable Clock Divider with Modulus Register

This block divides a master clock by a modulus that a small processor writes into a control register. The processor writes through a simple bus: a write strobe and a data byte. It can read the current modulus back at any time. The divider starts at divide-by-32.

A write is accepted only if its low six bits hold a value from 2 to 32. An accepted value waits in a pending register and is applied at the end of the output period that is running at the time, so the output never shows a shortened pulse. A rejected write leaves the register unchanged and raises a one-cycle error pulse.

Each output period is N input cycles. The output is high for floor(N/2) of them and low for the rest.

Top module: `clk_div_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 32, `switch_pending` is 0 and `wr_error` is 0. The counter restarts, so the first output period is a full 32 input cycles: 16 high, then 16 low.
- R2: Only bits [5:0] of `wr_data` form the requested modulus. Upper bits never affect acceptance or the stored value; writing 0xC6 stores 6.
- R3: A write whose bits [5:0] lie in 2..32 is stored in the pending register on that clock edge. `rd_data` then returns it in bits [5:0], with bits [7:6] reading zero.
- R4: A write whose bits [5:0] are 0, 1 or 33..63 is ignored, and the register keeps its previous value. `wr_error` is 1 in exactly the cycle after each such write.
- R5: A stored modulus becomes active only at the terminal count of the current period. The period in progress completes with the old modulus.
- R6: With an active modulus N, the output stays high for floor(N/2) input cycles and then low for N - floor(N/2) cycles.
- R7: `switch_pending` rises in the cycle after an accepted write. It falls in the cycle after the switch-over edge, unless another accepted write arrives on that same edge.
- R8: A write accepted on the same edge as a terminal count does not apply at that edge. It applies at the next terminal count.
- R9: If several accepted writes arrive before a switch-over, only the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Master input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits [5:0] hold the modulus |
| rd_data | output | 8 | Pending modulus read-back, upper bits zero |
| div_clk | output | 1 | Divided output clock, registered |
| switch_pending | output | 1 | High while a stored modulus awaits switch-over |
| wr_error | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench builds the divider with its default parameters: an 8-bit data path, a 6-bit modulus field, a legal range of 2 to 32 and a reset modulus of 32. These values make every field width in the requirements concrete. The illegal values just outside the range (0, 1 and 33) and the largest 6-bit code (63) can all be written directly. Writes with bits [7:6] set show that the masking of the upper bits has no side effects. Both the shortest period (2 cycles) and the longest (32 cycles) are short enough to observe many times within the run, including odd moduli and writes timed to land on the terminal-count edge.

// File: rtl/clk_div_reg.sv
module clk_div_reg #(
  parameter int DATA_W    = 8,
  parameter int MOD_W     = 6,
  parameter int MIN_MOD   = 2,
  parameter int MAX_MOD   = 32,
  parameter int RESET_MOD = 32
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              div_clk,
  output logic              switch_pending,
  output logic              wr_error
);
  localparam logic [MOD_W-1:0] MIN_V   = MOD_W'(MIN_MOD);
  localparam logic [MOD_W-1:0] MAX_V   = MOD_W'(MAX_MOD);
  localparam logic [MOD_W-1:0] RESET_V = MOD_W'(RESET_MOD);
  localparam logic [MOD_W-1:0] ONE     = MOD_W'(1);
  localparam int               PAD_W   = DATA_W - MOD_W;

  logic [MOD_W-1:0] cnt_q, active_q, stored_q;
  logic             pend_q, err_q, out_q;

  wire [MOD_W-1:0] wr_mod   = wr_data[MOD_W-1:0];
  wire             wr_ok    = wr_en && (wr_mod >= MIN_V) && (wr_mod <= MAX_V);
  wire             wr_bad   = wr_en && !wr_ok;
  wire             term     = (cnt_q == active_q - ONE);
  wire [MOD_W-1:0] cnt_nx   = term ? '0 : cnt_q + ONE;
  wire [MOD_W-1:0] active_nx = (term && pend_q) ? stored_q : active_q;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= RESET_V;
      stored_q <= RESET_V;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      out_q    <= 1'b1;
    end else begin
      cnt_q    <= cnt_nx;
      active_q <= active_nx;
      err_q    <= wr_bad;
      out_q    <= cnt_nx < (active_nx >> 1);
      if (wr_ok) begin
        stored_q <= wr_mod;
        pend_q   <= 1'b1;
      end else if (term) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign rd_data        = {{PAD_W{1'b0}}, stored_q};
  assign div_clk        = out_q;
  assign switch_pending = pend_q;
  assign wr_error       = err_q;

  // R3: active modulus always inside the legal range
  p_active_legal_r3: assert property (@(posedge clk_in) disable iff (rst)
    (active_q >= MIN_V) && (active_q <= MAX_V));

  // R4: an error pulse is caused only by a rejected write one cycle before
  p_err_cause_r4: assert property (@(posedge clk_in) disable iff (rst)
    wr_error |-> $past(wr_en) &&
      (($past(wr_data[MOD_W-1:0]) < MIN_V) || ($past(wr_data[MOD_W-1:0]) > MAX_V)));

  // R4: a rejected write leaves the read-back value unchanged
  p_reject_keeps_r4: assert property (@(posedge clk_in) disable iff (rst)
    $past(wr_bad) |-> rd_data == $past(rd_data));

  // R5: active modulus changes only on a terminal count
  p_switch_on_term_r5: assert property (@(posedge clk_in) disable iff (rst)
    !$stable(active_q) |-> $past(term));

  // R7: pending flag clears only at a switch-over
  p_pend_clear_r7: assert property (@(posedge clk_in) disable iff (rst)
    $fell(switch_pending) |-> $past(term));

  // R7: an accepted write always leaves the flag set
  p_pend_set_r7: assert property (@(posedge clk_in) disable iff (rst)
    wr_ok |=> switch_pending);
endmodule

// File: tb/tb_clk_div_reg.sv
module tb_clk_div_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk_in = 0, rst = 1, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       div_clk, switch_pending, wr_error;

  clk_div_reg dut (.clk_in(clk_in), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
                   .rd_data(rd_data), .div_clk(div_clk),
                   .switch_pending(switch_pending), .wr_error(wr_error));

  always #(CLK_PERIOD/2) clk_in = ~clk_in;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_cnt, m_act, m_val, m_pend, m_err, m_out;

  always @(posedge clk_in) begin
    int v, ok, bad, term, old_pend, old_val;
    if (rst) begin
      m_cnt = 0; m_act = 32; m_val = 32; m_pend = 0; m_err = 0; m_out = 1;
    end else begin
      v = wr_data % 64;
      ok = wr_en && v >= 2 && v <= 32;
      bad = wr_en && !ok;
      term = (m_cnt == m_act - 1);
      old_pend = m_pend; old_val = m_val;
      if (term) begin
        m_cnt = 0;
        if (old_pend) m_act = old_val;
      end else m_cnt = m_cnt + 1;
      if (ok) begin m_val = v; m_pend = 1; end
      else if (term) m_pend = 0;
      m_err = bad;
      m_out = (m_cnt < m_act / 2);
    end
  end

  task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk_in) begin
    cycles++;
    if (!rst) begin
      check(div_clk === m_out[0], {cur_req, " R5/R6"}, "div_clk", div_clk, m_out);
      check(rd_data === m_val[7:0], {cur_req, " R3"}, "rd_data", rd_data, m_val);
      check(switch_pending === m_pend[0], {cur_req, " R7"}, "switch_pending", switch_pending, m_pend);
      check(wr_error === m_err[0], {cur_req, " R4"}, "wr_error", wr_error, m_err);
    end
    if (cycles > WATCHDOG) begin
      check(0, "watchdog", "cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic wr(input int v);
    @(negedge clk_in); wr_en = 1; wr_data = v[7:0];
    @(negedge clk_in); wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_in);
  endtask

  task automatic measure(input string req, input int hi, input int lo);
    int h, l, prev;
    h = 0; l = 0;
    prev = div_clk;
    @(negedge clk_in);
    while (!(div_clk == 1 && prev == 0)) begin prev = div_clk; @(negedge clk_in); end
    while (div_clk == 1) begin h++; @(negedge clk_in); end
    while (div_clk == 0) begin l++; @(negedge clk_in); end
    check(h == hi, req, "high cycles", h, hi);
    check(l == lo, req, "low cycles", l, lo);
  endtask

  initial begin
    idle(3);
    rst = 0;
    #1;
    cur_req = "R1";
    check(rd_data == 8'd32, "R1", "reset rd_data", rd_data, 32);
    check(switch_pending == 0, "R1", "reset pending", switch_pending, 0);
    check(wr_error == 0, "R1", "reset error", wr_error, 0);
    check(div_clk == 1, "R1", "reset div_clk", div_clk, 1);
    measure("R1", 16, 16);

    cur_req = "R6";
    wr(4);
    check(switch_pending == 1, "R7", "pending after write", switch_pending, 1);
    idle(40); measure("R6", 2, 2);
    check(switch_pending == 0, "R7", "pending after switch", switch_pending, 0);
    wr(3); idle(10); measure("R6", 1, 2);
    wr(5); idle(10); measure("R6", 2, 3);

    cur_req = "R2";
    wr(8'hC6);
    check(rd_data == 8'd6, "R2", "masked write", rd_data, 6);
    idle(10); measure("R2", 3, 3);

    cur_req = "R4";
    wr(0);  check(rd_data == 8'd6, "R4", "write 0 ignored", rd_data, 6);
    wr(1);  check(rd_data == 8'd6, "R4", "write 1 ignored", rd_data, 6);
    wr(33); check(rd_data == 8'd6, "R4", "write 33 ignored", rd_data, 6);
    wr(63); check(rd_data == 8'd6, "R4", "write 63 ignored", rd_data, 6);
    wr(8'hC0); check(rd_data == 8'd6, "R4", "write 0xC0 ignored", rd_data, 6);
    measure("R4", 3, 3);

    cur_req = "R5";
    wr(32); idle(3);
    check(switch_pending == 1, "R5", "still pending mid-period", switch_pending, 1);
    idle(40); measure("R5", 16, 16);

    cur_req = "R8";
    wr(2); idle(5);
    while (m_cnt != m_act - 1) @(negedge clk_in);
    wr_en = 1; wr_data = 8'd7;
    @(negedge clk_in); wr_en = 0; wr_data = 0;
    check(switch_pending == 1, "R8", "pending after terminal write", switch_pending, 1);
    idle(6); measure("R8", 3, 4);

    cur_req = "R9";
    wr(10); wr(12); wr(9);
    check(rd_data == 8'd9, "R9", "last write read-back", rd_data, 9);
    idle(30); measure("R9", 4, 5);

    cur_req = "R3";
    wr(2); idle(20); measure("R3", 1, 1);
    wr(32); idle(40); measure("R3", 16, 16);

    cur_req = "R1";
    @(negedge clk_in); rst = 1; wr_en = 1; wr_data = 8'd4;
    @(negedge clk_in); rst = 0; wr_en = 0; wr_data = 0;
    #1;
    check(rd_data == 8'd32, "R1", "rd_data after re-reset", rd_data, 32);
    measure("R1", 16, 16);

    idle(5);
    finish_run();
  end
endmodule